// File: doc/BRIEF.md
# M2-Cycle Interrupt Down-Timer

This block is a 16-bit interrupt timer that runs off the CPU's M2 clock, one count per M2 cycle. Software loads a 16-bit reload value through two byte-wide write ports, low byte first and then high byte. A write to the control port then moves that value into the live counter, sets or clears the run enable from data bit 0, and clears any pending interrupt.

While the timer runs, the counter steps down once per cycle. On the edge where it arrives at zero it raises a level interrupt. It then stays at zero and holds the interrupt until software writes the control port again. If a control write enables the timer while the reload value is zero, the interrupt is raised on that same edge.

The write ports sit at the low offsets of the CPU window from $8000. The address is decoded through the mask $800F, so every mirror of an offset selects the same port.

Top module: `irq_down_timer`

## Requirements
- R1: A write whose address ANDed with $800F equals $800B stores wr_data into bits 7:0 of the reload value.
- R2: A write whose address ANDed with $800F equals $800C stores wr_data into bits 15:8 of the reload value.
- R3: A reload-value write leaves the running count untouched. The interrupt still arrives at the time set by the value that was present at the last control write.
- R4: A control write (address ANDed with $800F equals $800A) loads the reload value into the counter. Data bit 0 set starts counting and bit 0 clear stops it. A stopped timer never raises the interrupt.
- R5: Every control write clears a pending interrupt, unless R7 applies to that write.
- R6: After an enabling control write with reload value N > 0, irq is low for the next N-1 cycles and rises on the N-th rising edge after the write edge.
- R7: An enabling control write with reload value zero raises irq on the write's own edge.
- R8: Once the count reaches zero it stays at zero and irq stays high until the next control write.
- R9: Reset clears the reload value, the counter, the enable and irq.
- R10: The port decode ignores address bits 14:4. A write with address bit 15 clear, or with an offset other than $A, $B or $C, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | M2 clock; one count per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The embedded assertions check four things on every cycle. The count steps down by exactly one while it runs. It never wraps below zero, and irq stays high while it rests at zero. A clearing control write drops irq, and an enabling write with a zero reload value raises it. Finally, irq only rises after a control write or while the timer runs, and the reload value changes only when one of its byte lanes is written. Other behaviour needs a sequence of writes, so only the bench scenarios can show it. That covers the exact cycle on which the interrupt fires for a given reload value, the mid-count reload write having no effect, mirrored and foreign addresses, and what reset leaves behind.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

  // Saturating one-step decrement: zero stays zero.
  function automatic logic [31:0] step_down(input logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

  // True when the next step lands on (or stays at) zero.
  function automatic logic lands_on_zero(input logic [31:0] c);
    return c <= 32'd1;
  endfunction

  // Masked address compare used by the port decoder.
  function automatic logic port_hit(input logic [31:0] a, input logic [31:0] mask,
                                    input logic [31:0] match);
    return (a & mask) == match;
  endfunction

endpackage

// File: rtl/irqtmr_decode.sv
module irqtmr_decode #(
  parameter int ADDR_W   = 16,
  parameter int LANES    = 2,
  parameter int DEC_MASK = 'h800F,
  parameter int CTRL_OFS = 'h800A,
  parameter int LANE_OFS = 'h800B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  lane_wr,
  output logic              ctrl_wr
);
  import irqtmr_pkg::*;

  logic [31:0] addr_ext;
  assign addr_ext = 32'(wr_addr);

  assign ctrl_wr = wr_en && port_hit(addr_ext, 32'(DEC_MASK), 32'(CTRL_OFS));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_wr[i] = wr_en && port_hit(addr_ext, 32'(DEC_MASK), 32'(LANE_OFS + i));
  end

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lane_wr, ctrl_wr}));
endmodule

// File: rtl/irqtmr_latch.sv
module irqtmr_latch #(
  parameter int DATA_W = 8,
  parameter int LANES  = 2,
  localparam int CNT_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  reload
);
  for (genvar i = 0; i < LANES; i++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          byte_q <= '0;
      else if (lane_wr[i]) byte_q <= wr_data;
    end
    assign reload[i*DATA_W +: DATA_W] = byte_q;
  end

  // R1 R2
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr == '0) |=> $stable(reload));
endmodule

// File: rtl/irqtmr_core.sv
module irqtmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic [CNT_W-1:0] reload,
  output logic             irq
);
  import irqtmr_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             irq_q;

  // Named internal events for the checks below.
  logic tick;
  logic hits_zero;
  logic fire_on_load;
  assign tick         = run_q && !ctrl_wr;
  assign hits_zero    = tick && lands_on_zero(32'(cnt_q));
  assign fire_on_load = ctrl_wr && ctrl_en && (reload == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (ctrl_wr) begin
      cnt_q <= reload;
      run_q <= ctrl_en;
      irq_q <= fire_on_load;
    end else if (tick) begin
      cnt_q <= CNT_W'(step_down(32'(cnt_q)));
      if (hits_zero) irq_q <= 1'b1;
    end
  end

  assign irq = irq_q;

  // R6
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  // R8
  rest_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt_q == '0) |=> (cnt_q == '0) && irq_q);

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !fire_on_load |=> !irq_q);

  // R7
  zero_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_on_load |=> irq_q);

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(ctrl_wr) || $past(run_q)));
endmodule

// File: rtl/irq_down_timer.sv
module irq_down_timer #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LANES    = 2,
  parameter int DEC_MASK = 'h800F,
  parameter int CTRL_OFS = 'h800A,
  parameter int LANE_OFS = 'h800B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  localparam int CNT_W = DATA_W * LANES;

  logic [LANES-1:0] lane_wr;
  logic             ctrl_wr;
  logic [CNT_W-1:0] reload;

  irqtmr_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DEC_MASK(DEC_MASK),
    .CTRL_OFS(CTRL_OFS), .LANE_OFS(LANE_OFS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .lane_wr(lane_wr), .ctrl_wr(ctrl_wr)
  );

  irqtmr_latch #(.DATA_W(DATA_W), .LANES(LANES)) u_latch (
    .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .wr_data(wr_data), .reload(reload)
  );

  irqtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(wr_data[0]),
    .reload(reload), .irq(irq)
  );
endmodule

// File: tb/irq_down_timer_test.sv
module irq_down_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_down_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  // Vector: {enable bit, 16-bit reload value}
  localparam int NVEC = 7;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'h0003}, {1'b1, 16'h0001}, {1'b1, 16'h0000}, {1'b1, 16'h0102},
    {1'b0, 16'h0005}, {1'b0, 16'h0000}, {1'b1, 16'h0011}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic load_and_go(input logic [15:0] v, input logic en);
    bus_write(16'h800B, v[7:0]);
    bus_write(16'h800C, v[15:8]);
    bus_write(16'h800A, {7'd0, en});
  endtask

  // After an enabling control write, expect irq exactly n edges later.
  task automatic expect_fire(input int n, input string tag);
    if (n == 0) chk({tag, " R7 zero reload fires at once"}, irq, 1'b1);
    else begin
      chk({tag, " R6 low right after load"}, irq, 1'b0);
      repeat (n - 1) @(negedge clk);
      chk({tag, " R6 low one edge early"}, irq, 1'b0);
      @(negedge clk);
      chk({tag, " R6 high on n-th edge"}, irq, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 irq low in reset", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 irq low after reset", irq, 1'b0);

    // Table walk: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      load_and_go(VEC[i][15:0], VEC[i][16]);
      if (VEC[i][16]) expect_fire(int'(VEC[i][15:0]), "vec");
      else begin
        repeat (12) @(negedge clk);
        chk("R4 stopped timer stays quiet", irq, 1'b0);
      end
      bus_write(16'h800A, 8'h00);
      chk("R5 control write clears irq", irq, 1'b0);
    end

    // R8: holds at zero, irq stays high, no wrap
    load_and_go(16'h0002, 1'b1);
    expect_fire(2, "R8 setup");
    repeat (40) @(negedge clk);
    chk("R8 irq held at zero", irq, 1'b1);
    bus_write(16'h800A, 8'h00);
    chk("R5 ack after hold", irq, 1'b0);

    // R3: reload write mid-count does not disturb running count
    load_and_go(16'h000A, 1'b1);
    bus_write(16'h800B, 8'h50);
    bus_write(16'h800C, 8'h00);
    repeat (5) @(negedge clk);
    chk("R3 low before original expiry", irq, 1'b0);
    @(negedge clk);
    chk("R3 fires at original count", irq, 1'b1);
    // new reload (0x0050) only takes effect on the next control write
    bus_write(16'h800A, 8'h01);
    expect_fire(16'h0050, "R3 new reload");
    bus_write(16'h800A, 8'h00);

    // R10: mirrors decode, foreign addresses ignored
    bus_write(16'hFFFB, 8'h04);
    bus_write(16'h8F3C, 8'h00);
    bus_write(16'h000B, 8'hFF);
    bus_write(16'h700C, 8'hFF);
    bus_write(16'h800D, 8'hFF);
    bus_write(16'h8008, 8'hFF);
    bus_write(16'h000A, 8'h01);
    repeat (8) @(negedge clk);
    chk("R10 foreign control address ignored", irq, 1'b0);
    bus_write(16'hC0FA, 8'h01);
    expect_fire(4, "R10 mirrored ports");
    bus_write(16'h800A, 8'h00);

    // R9: reset mid-count clears enable, count and reload
    load_and_go(16'h0007, 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 irq low after mid-run reset", irq, 1'b0);
    repeat (12) @(negedge clk);
    chk("R9 enable cleared by reset", irq, 1'b0);
    bus_write(16'h800A, 8'h01);
    chk("R9 reload cleared to zero by reset", irq, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule